// File: doc/BRIEF.md
# Word-granular self-invalidating L1 data cache controller

This block is the private first-level data cache controller of one core in a machine that runs in parallel phases. It keeps coherence per word, not per line: every word is Invalid, Valid or Registered, and it carries a small region identifier and a touched bit. A line holds several words under one tag. Writes to one word never disturb the other words of the same line. The block sends no invalidation messages and keeps no sharer lists.

Loads that miss fetch a single word from the shared second level. A store makes its word Registered and sends one registration request to the second level, which carries the written data. The second level acknowledges each registration, and the controller counts the requests still waiting for their acknowledgement. When the core ends a phase, it strobes the phase-end input together with a mask of the regions written in that phase. The controller waits until no registration is outstanding. It then walks the array one line per cycle and drops every Valid word whose region was written and which this core did not read during the phase. At the end of the walk it clears all touched bits and pulses done.

Address split: word offset in the low bits, then the line index, then the tag. L2 request kind 0 is a word fetch and kind 1 is a registration. Bit i of the phase mask marks region i as written.

Top module: `l1si_ctrl`

## Requirements
- R1: After reset, core_req_ready is 1 and core_resp_valid, l2_req_valid and phase_done are 0. Every word is Invalid, so the first load of any address issues a fetch.
- R2: A load of an Invalid word, or of a word whose line holds another tag, issues one fetch (l2_req_kind 0, l2_req_addr equal to the load address) in the cycle after acceptance. The response arrives the cycle after l2_resp_valid and carries l2_resp_rdata. The word is Valid from then on.
- R3: A load of a Valid or Registered word whose tag matches is answered in the cycle after acceptance with the stored word. It issues no L2 request and sets the word's touched bit.
- R4: A store to an Invalid or Valid word issues exactly one registration (l2_req_kind 1, address and data of the store) in the cycle after acceptance. A store to a Registered word issues none. Either store is answered in the cycle after acceptance, and later loads return the stored data.
- R5: A registration stays outstanding until l2_ack_valid acknowledges it. The phase walk does not begin while any registration is outstanding, and it begins one cycle after the last acknowledgement is counted.
- R6: During the walk, a Valid word becomes Invalid if the mask bit of its region is 1 and its touched bit is 0. A Valid word whose region bit is 0 stays Valid.
- R7: Registered words keep their state and data through a walk, whatever the mask says.
- R8: The walk takes one cycle per line. With nothing outstanding, phase_done is a one-cycle pulse seen LINES+1 cycles after the phase_end strobe.
- R9: All touched bits are cleared when the walk completes. A word read only before the previous phase end is therefore dropped by the next walk whose mask covers its region.
- R10: A store to one word of a line leaves the state and data of the other words of that line unchanged.
- R11: A request whose tag differs from the stored tag of its line replaces the line: the other words become Invalid, and a store from this case also registers.
- R12: From the phase_end strobe until phase_done, no core request is accepted. core_req_ready is 0, and neither a core response nor an L2 request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request present |
| core_req_write | input | 1 | 1 store, 0 load |
| core_req_addr | input | AW | Word address |
| core_req_wdata | input | DW | Store data |
| core_req_region | input | RW | Region id of the addressed word |
| core_req_ready | output | 1 | Request accepted this cycle when valid |
| core_resp_valid | output | 1 | Response strobe |
| core_resp_rdata | output | DW | Load data (store data echoed on stores) |
| l2_req_valid | output | 1 | One-cycle L2 request strobe |
| l2_req_kind | output | 1 | 0 fetch, 1 registration |
| l2_req_addr | output | AW | Word address of the request |
| l2_req_wdata | output | DW | Data carried by a registration |
| l2_resp_valid | input | 1 | Fetch data strobe |
| l2_resp_rdata | input | DW | Fetched word |
| l2_ack_valid | input | 1 | Acknowledges one registration |
| phase_end | input | 1 | Phase-end strobe |
| phase_mask | input | NREG | Written-region mask, bit i for region i |
| phase_done | output | 1 | One-cycle pulse when the walk is finished |

## Verification
A wrong internal word state shows up only at the next access to that word. A word that should be Invalid answers a load without any fetch. A word that was wrongly dropped fetches again. A stale Registered flag suppresses the registration of a store, and the missing L2 strobe is visible in the cycle after acceptance. The bench therefore probes every word with a load or store after each state-changing event and reads the state from the presence or absence of L2 traffic one cycle later. A miscounted outstanding registration or walk length moves the phase_done pulse by whole cycles, and the bench counts those cycles exactly.

// File: rtl/l1si_pkg.sv
package l1si_pkg;

    typedef enum logic [1:0] {
        WS_INV = 2'd0,
        WS_VAL = 2'd1,
        WS_REG = 2'd2
    } wstate_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_WAIT = 2'd1,
        F_WALK = 2'd2
    } fsm_e;

    localparam logic KIND_FETCH = 1'b0;
    localparam logic KIND_REG   = 1'b1;

endpackage

// File: rtl/l1si_addr_split.sv
module l1si_addr_split #(
    parameter int AW   = 12,
    parameter int OFFW = 1,
    parameter int IDXW = 3,
    localparam int TAGW = AW - OFFW - IDXW
) (
    input  logic [AW-1:0]   addr_i,
    output logic [TAGW-1:0] tag_o,
    output logic [IDXW-1:0] idx_o,
    output logic [OFFW-1:0] off_o
);
    assign off_o = addr_i[OFFW-1:0];
    assign idx_o = addr_i[OFFW +: IDXW];
    assign tag_o = addr_i[AW-1 -: TAGW];
endmodule

// File: rtl/l1si_line_sweep.sv
module l1si_line_sweep
    import l1si_pkg::*;
#(
    parameter int WPL  = 2,
    parameter int RW   = 3,
    localparam int NREG = 1 << RW
) (
    input  wstate_e [WPL-1:0]         st_i,
    input  logic    [WPL-1:0][RW-1:0] rg_i,
    input  logic    [WPL-1:0]         tch_i,
    input  logic    [NREG-1:0]        mask_i,
    output wstate_e [WPL-1:0]         st_o
);
    for (genvar w = 0; w < WPL; w++) begin : g_word
        logic stale;
        assign stale   = (st_i[w] == WS_VAL) && mask_i[rg_i[w]] && !tch_i[w];
        assign st_o[w] = stale ? WS_INV : st_i[w];
    end
endmodule

// File: rtl/l1si_reg_tracker.sv
module l1si_reg_tracker #(
    parameter int MAXO = 15,
    localparam int CW  = $clog2(MAXO + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CW'(inc_i) - CW'(dec_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_ACK_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> cnt_q != '0); // R5
    AST_PENDING_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |-> cnt_q != CW'(MAXO)); // R5
endmodule

// File: rtl/l1si_ctrl.sv
module l1si_ctrl
    import l1si_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DW    = 16,
    parameter int LINES = 8,
    parameter int WPL   = 2,
    parameter int RW    = 3,
    parameter int MAXO  = 15,
    localparam int NREG = 1 << RW,
    localparam int OFFW = (WPL > 1) ? $clog2(WPL) : 1,
    localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAGW = AW - OFFW - IDXW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_req_valid,
    input  logic            core_req_write,
    input  logic [AW-1:0]   core_req_addr,
    input  logic [DW-1:0]   core_req_wdata,
    input  logic [RW-1:0]   core_req_region,
    output logic            core_req_ready,
    output logic            core_resp_valid,
    output logic [DW-1:0]   core_resp_rdata,
    output logic            l2_req_valid,
    output logic            l2_req_kind,
    output logic [AW-1:0]   l2_req_addr,
    output logic [DW-1:0]   l2_req_wdata,
    input  logic            l2_resp_valid,
    input  logic [DW-1:0]   l2_resp_rdata,
    input  logic            l2_ack_valid,
    input  logic            phase_end,
    input  logic [NREG-1:0] phase_mask,
    output logic            phase_done
);

    typedef struct packed {
        fsm_e                                     fsm;
        logic [IDXW-1:0]                          walk_idx;
        logic                                     pend;
        logic [NREG-1:0]                          mask;
        logic                                     resp_v;
        logic [DW-1:0]                            resp_d;
        logic                                     l2_v;
        logic                                     l2_kind;
        logic [AW-1:0]                            l2_addr;
        logic [DW-1:0]                            l2_data;
        logic                                     done;
        logic [AW-1:0]                            miss_addr;
        logic [RW-1:0]                            miss_rg;
        logic [LINES-1:0][TAGW-1:0]               tag;
        wstate_e [LINES-1:0][WPL-1:0]             ws;
        logic [LINES-1:0][WPL-1:0][RW-1:0]        rg;
        logic [LINES-1:0][WPL-1:0]                tch;
        logic [LINES-1:0][WPL-1:0][DW-1:0]        dat;
    } ctl_s;

    ctl_s s_d, s_q;

    // address decode for the incoming request and for the pending miss
    logic [TAGW-1:0] c_tag, m_tag;
    logic [IDXW-1:0] c_idx, m_idx;
    logic [OFFW-1:0] c_off, m_off;

    l1si_addr_split #(.AW(AW), .OFFW(OFFW), .IDXW(IDXW)) u_split_core (
        .addr_i(core_req_addr), .tag_o(c_tag), .idx_o(c_idx), .off_o(c_off)
    );
    l1si_addr_split #(.AW(AW), .OFFW(OFFW), .IDXW(IDXW)) u_split_miss (
        .addr_i(s_q.miss_addr), .tag_o(m_tag), .idx_o(m_idx), .off_o(m_off)
    );

    // phase-end filter applied to the line under the walk pointer
    wstate_e [WPL-1:0] sweep_st;
    l1si_line_sweep #(.WPL(WPL), .RW(RW)) u_sweep (
        .st_i  (s_q.ws[s_q.walk_idx]),
        .rg_i  (s_q.rg[s_q.walk_idx]),
        .tch_i (s_q.tch[s_q.walk_idx]),
        .mask_i(s_q.mask),
        .st_o  (sweep_st)
    );

    // outstanding registration counter
    logic reg_inc, none_pending;
    l1si_reg_tracker #(.MAXO(MAXO)) u_track (
        .clk(clk), .rst_n(rst_n), .inc_i(reg_inc), .dec_i(l2_ack_valid), .zero_o(none_pending)
    );

    logic    accept, tag_hit, m_tag_hit;
    wstate_e cur_ws;

    assign core_req_ready = (s_q.fsm == F_IDLE) && !s_q.pend && !phase_end;
    assign accept         = core_req_valid && core_req_ready;

    always_comb begin
        s_d       = s_q;
        s_d.resp_v = 1'b0;
        s_d.l2_v   = 1'b0;
        s_d.done   = 1'b0;
        reg_inc    = 1'b0;
        tag_hit    = (s_q.tag[c_idx] == c_tag);
        m_tag_hit  = (s_q.tag[m_idx] == m_tag);
        cur_ws     = s_q.ws[c_idx][c_off];

        if (phase_end && s_q.fsm != F_WALK) begin
            s_d.pend = 1'b1;
            s_d.mask = phase_mask;
        end

        unique case (s_q.fsm)
            F_IDLE: begin
                if ((s_q.pend || phase_end) && none_pending) begin
                    s_d.fsm      = F_WALK;
                    s_d.walk_idx = '0;
                    s_d.pend     = 1'b0;
                end else if (accept) begin
                    if (core_req_write) begin
                        if (!tag_hit) begin
                            s_d.tag[c_idx] = c_tag;
                            for (int w = 0; w < WPL; w++) begin
                                s_d.ws[c_idx][w]  = WS_INV;
                                s_d.tch[c_idx][w] = 1'b0;
                            end
                        end
                        s_d.dat[c_idx][c_off] = core_req_wdata;
                        s_d.rg[c_idx][c_off]  = core_req_region;
                        s_d.ws[c_idx][c_off]  = WS_REG;
                        if (!(tag_hit && cur_ws == WS_REG)) begin
                            s_d.l2_v    = 1'b1;
                            s_d.l2_kind = KIND_REG;
                            s_d.l2_addr = core_req_addr;
                            s_d.l2_data = core_req_wdata;
                            reg_inc     = 1'b1;
                        end
                        s_d.resp_v = 1'b1;
                        s_d.resp_d = core_req_wdata;
                    end else if (tag_hit && cur_ws != WS_INV) begin
                        s_d.resp_v             = 1'b1;
                        s_d.resp_d             = s_q.dat[c_idx][c_off];
                        s_d.tch[c_idx][c_off]  = 1'b1;
                    end else begin
                        s_d.l2_v      = 1'b1;
                        s_d.l2_kind   = KIND_FETCH;
                        s_d.l2_addr   = core_req_addr;
                        s_d.l2_data   = '0;
                        s_d.miss_addr = core_req_addr;
                        s_d.miss_rg   = core_req_region;
                        s_d.fsm       = F_WAIT;
                    end
                end
            end
            F_WAIT: begin
                if (l2_resp_valid) begin
                    if (!m_tag_hit) begin
                        s_d.tag[m_idx] = m_tag;
                        for (int w = 0; w < WPL; w++) begin
                            s_d.ws[m_idx][w]  = WS_INV;
                            s_d.tch[m_idx][w] = 1'b0;
                        end
                    end
                    s_d.dat[m_idx][m_off] = l2_resp_rdata;
                    s_d.rg[m_idx][m_off]  = s_q.miss_rg;
                    s_d.ws[m_idx][m_off]  = WS_VAL;
                    s_d.tch[m_idx][m_off] = 1'b1;
                    s_d.resp_v            = 1'b1;
                    s_d.resp_d            = l2_resp_rdata;
                    s_d.fsm               = F_IDLE;
                end
            end
            F_WALK: begin
                s_d.ws[s_q.walk_idx] = sweep_st;
                if (s_q.walk_idx == IDXW'(LINES - 1)) begin
                    s_d.tch  = '0;
                    s_d.fsm  = F_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.walk_idx = IDXW'(s_q.walk_idx + 1'b1);
                end
            end
            default: s_d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign core_resp_valid = s_q.resp_v;
    assign core_resp_rdata = s_q.resp_d;
    assign l2_req_valid    = s_q.l2_v;
    assign l2_req_kind     = s_q.l2_kind;
    assign l2_req_addr     = s_q.l2_addr;
    assign l2_req_wdata    = s_q.l2_data;
    assign phase_done      = s_q.done;

    AST_WALK_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fsm == F_WALK) |-> none_pending); // R5
    AST_WALK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fsm == F_WALK) |-> (!core_req_ready && !l2_req_valid && !core_resp_valid)); // R12
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |=> !phase_done); // R8
    AST_FILL_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        l2_resp_valid |-> (s_q.fsm == F_WAIT)); // R2
    AST_FETCH_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && l2_req_kind == KIND_FETCH) |-> (s_q.fsm == F_WAIT)); // R2
endmodule

// File: tb/sim_l1si_ctrl.sv
module sim_l1si_ctrl;
    localparam int AW = 12, DW = 16, LINES = 8, WPL = 2, RW = 3, NREG = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic core_req_valid = 0, core_req_write = 0;
    logic [AW-1:0] core_req_addr = '0;
    logic [DW-1:0] core_req_wdata = '0;
    logic [RW-1:0] core_req_region = '0;
    logic core_req_ready, core_resp_valid;
    logic [DW-1:0] core_resp_rdata;
    logic l2_req_valid, l2_req_kind;
    logic [AW-1:0] l2_req_addr;
    logic [DW-1:0] l2_req_wdata;
    logic l2_resp_valid = 0, l2_ack_valid = 0, phase_end = 0, phase_done;
    logic [DW-1:0] l2_resp_rdata = '0;
    logic [NREG-1:0] phase_mask = '0;

    int errors = 0, checks = 0, pending = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    l1si_ctrl u0 (.*);

    function automatic int l2val(int a);  return (a * 37 + 11) & 16'hFFFF; endfunction
    function automatic int wval(int a, int k); return (a * 256 + k * 16 + 3) & 16'hFFFF; endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(int a, output bit fetched, output int data);
        @(negedge clk);
        core_req_valid = 1; core_req_write = 0;
        core_req_addr = AW'(a); core_req_region = RW'(a % 8);
        @(negedge clk);
        core_req_valid = 0;
        fetched = l2_req_valid;
        if (fetched) begin
            chk(l2_req_kind == 1'b0 && l2_req_addr == AW'(a), "R2 fetch kind/addr", int'(l2_req_addr), a);
            l2_resp_valid = 1; l2_resp_rdata = DW'(l2val(a));
            @(negedge clk);
            l2_resp_valid = 0;
        end
        chk(core_resp_valid == 1'b1, "R3 response strobe", int'(core_resp_valid), 1);
        data = int'(core_resp_rdata);
    endtask

    task automatic wr(int a, int d, output bit regd);
        @(negedge clk);
        core_req_valid = 1; core_req_write = 1;
        core_req_addr = AW'(a); core_req_region = RW'(a % 8); core_req_wdata = DW'(d);
        @(negedge clk);
        core_req_valid = 0; core_req_write = 0;
        regd = l2_req_valid;
        if (regd) begin
            pending++;
            chk(l2_req_kind == 1'b1 && l2_req_addr == AW'(a) && l2_req_wdata == DW'(d),
                "R4 registration fields", int'(l2_req_wdata), d);
        end
        chk(core_resp_valid == 1'b1, "R4 store response", int'(core_resp_valid), 1);
    endtask

    task automatic ack_all();
        while (pending > 0) begin
            @(negedge clk); l2_ack_valid = 1;
            pending--;
        end
        @(negedge clk); l2_ack_valid = 0;
    endtask

    // phase end with nothing outstanding; optionally a load held during the walk
    task automatic phase(logic [NREG-1:0] m, bit hold);
        int n;
        @(negedge clk);
        phase_end = 1; phase_mask = m;
        if (hold) begin core_req_valid = 1; core_req_write = 0; core_req_addr = '0; end
        n = 0;
        while (n < 100) begin
            @(negedge clk);
            phase_end = 0;
            n++;
            if (phase_done) break;
            if (n >= LINES) core_req_valid = 0;
            chk(!core_req_ready && !core_resp_valid && !l2_req_valid, "R12 stalled during walk",
                int'(core_req_ready), 0);
        end
        core_req_valid = 0;
        chk(n == LINES + 1, "R8 walk length", n, LINES + 1);
        @(negedge clk);
        chk(phase_done == 1'b0, "R8 done single cycle", int'(phase_done), 0);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        bit f, r;
        int d, n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(core_req_ready == 1'b1, "R1 ready after reset", int'(core_req_ready), 1);
        chk(!core_resp_valid && !l2_req_valid && !phase_done, "R1 outputs idle", int'(l2_req_valid), 0);

        // R1/R2: every word starts Invalid and fetches
        for (int a = 0; a < LINES * WPL; a++) begin
            rd(a, f, d);
            chk(f == 1'b1, "R1 first load fetches", int'(f), 1);
            chk(d == l2val(a), "R2 fetched data", d, l2val(a));
        end
        // R3: now Valid, loads hit without L2 traffic
        for (int a = 0; a < LINES * WPL; a++) begin
            rd(a, f, d);
            chk(f == 1'b0, "R3 hit no fetch", int'(f), 0);
            chk(d == l2val(a), "R3 hit data", d, l2val(a));
        end

        // R9: touched words survive, touched cleared, then mask 0x55 drops even regions (R6)
        phase(8'hFF, 1'b1);
        phase(8'h55, 1'b0);
        for (int a = 0; a < LINES * WPL; a++) begin
            rd(a, f, d);
            chk(f == ((a % 8) % 2 == 0), "R6 R9 drop masked untouched", int'(f), int'((a % 8) % 2 == 0));
            chk(d == l2val(a), "R6 data after walk", d, l2val(a));
        end

        // R4 stores from Valid register once; R10 neighbour word unaffected
        for (int a = 0; a < LINES * WPL; a += 2) begin
            wr(a, wval(a, 1), r);
            chk(r == 1'b1, "R4 store from Valid registers", int'(r), 1);
            wr(a, wval(a, 2), r);
            chk(r == 1'b0, "R4 store to Registered silent", int'(r), 0);
            rd(a + 1, f, d);
            chk(f == 1'b0 && d == l2val(a + 1), "R10 neighbour word kept", d, l2val(a + 1));
        end

        // R5: walk deferred while registrations outstanding
        @(negedge clk); phase_end = 1; phase_mask = 8'hFF;
        @(negedge clk); phase_end = 0;
        for (int k = 0; k < 2 * LINES; k++) begin
            chk(phase_done == 1'b0 && core_req_ready == 1'b0, "R5 walk waits for acks", int'(phase_done), 0);
            @(negedge clk);
        end
        while (pending > 1) begin
            l2_ack_valid = 1; pending--;
            @(negedge clk);
        end
        l2_ack_valid = 1; pending--;
        n = 0;
        while (n < 100) begin
            @(negedge clk);
            l2_ack_valid = 0;
            n++;
            if (phase_done) break;
        end
        chk(n == LINES + 2, "R5 walk starts after last ack", n, LINES + 2);

        // second walk: touched cleared by the first; R7 registered kept, untouched Valid dropped
        phase(8'hFF, 1'b0);
        for (int a = 0; a < LINES * WPL; a++) begin
            rd(a, f, d);
            if (a % 2 == 0) begin
                chk(f == 1'b0 && d == wval(a, 2), "R7 registered kept", d, wval(a, 2));
            end else begin
                chk(f == 1'b1 && d == l2val(a), "R9 untouched Valid dropped", int'(f), 1);
            end
        end

        // R11 tag replacement: address 19 maps to line 1 (index bits 3:1), tag 1
        wr(19, wval(19, 3), r);
        chk(r == 1'b1, "R11 store on tag mismatch registers", int'(r), 1);
        rd(18, f, d);
        chk(f == 1'b1 && d == l2val(18), "R11 other word invalid", int'(f), 1);
        rd(19, f, d);
        chk(f == 1'b0 && d == wval(19, 3), "R4 load returns stored data", d, wval(19, 3));
        rd(2, f, d);
        chk(f == 1'b1 && d == l2val(2), "R11 old tag refetched", int'(f), 1);
        ack_all();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    end
endmodule